// File: doc/BRIEF.md
# Quadword Access Splitting Sequencer

This block sits in a load/store path and breaks each 16-byte (quadword) memory operation into two 8-byte beats that are handed downstream one at a time. The first beat uses the effective address and the second uses the effective address plus 8, so memory is always walked upward. The register that goes with each beat is one half of an even/odd register pair. Which half goes first depends on the current byte order.

Before any beat is issued, the block screens each request. A reserved quad load whose index or base register collides with its destination is rejected as an illegal form. Reserved quad loads that are not 16-byte aligned, and plain quad loads that are not 16-byte aligned in little-endian mode, raise an alignment exception. This stops the first beat from overwriting a base register when the second beat might then fault. Requests that are not quadword pass through as a single beat. The block holds the upstream side stalled while a split operation is in flight.

Top module: `quad_split_seq`

## Requirements
- R1: A quad operation (kind 1 plain load, 2 store, 3 reserved load, 4 conditional store) that raises no exception produces exactly two beats. The first beat carries the effective address and the second carries the effective address plus 8.
- R2: In little-endian mode (`req_big_endian`=0) the first beat's register is the base register with bit 0 forced to 1 and the second beat's register is the base register unchanged. In big-endian mode the two are swapped.
- R3: `beat_repeat` is 1 on both beats of a quad operation, and `beat_second` is 1 only on its second beat.
- R4: `beat_irq_inhibit` is 1 on the second beat of a quad operation and 0 on every other beat.
- R5: A plain quad load (kind 1) in little-endian mode whose address bits [3:0] are not zero gives a one-cycle `align_exc` pulse and issues no beat.
- R6: A reserved quad load (kind 3) whose address bits [3:0] are not zero gives a one-cycle `align_exc` pulse and issues no beat, in either byte order.
- R7: A reserved quad load whose index register A or index register B equals its base register gives a one-cycle `illegal_exc` pulse and issues no beat. This check takes precedence over the alignment check, and only one of the two pulses fires.
- R8: Quad stores of kind 2 or 4, and plain quad loads in big-endian mode, are issued normally at any address that is 8-byte aligned but not 16-byte aligned.
- R9: `up_stall` is 1 from the cycle after a request is accepted until the cycle after its last beat is handed downstream. A request presented while `up_stall` is 1 is ignored.
- R10: `flush`, like `rst`, clears any beat in flight, including a pending second beat, at the next clock edge. The block is idle with `up_stall` low in the following cycle.
- R11: A beat is handed off only in a cycle where `dn_ready` is 1. While `beat_valid` is 1 and `dn_ready` is 0, the address, register and all flags stay stable.
- R12: A request of kind 0 or of kinds 5 to 7 issues one beat with the address and register unchanged and with `beat_repeat`, `beat_second` and `beat_irq_inhibit` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Cancels any operation in flight |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | 0 single, 1 quad load, 2 quad store, 3 reserved quad load, 4 conditional quad store |
| req_addr | input | AW | Effective address |
| req_big_endian | input | 1 | 1 = big-endian mode |
| req_rt | input | RW | Base (destination or source) register number |
| req_ra | input | RW | Index register A number |
| req_rb | input | RW | Index register B number |
| dn_ready | input | 1 | Downstream accepts the current beat |
| up_stall | output | 1 | Upstream must hold off |
| beat_valid | output | 1 | Beat present |
| beat_addr | output | AW | Beat access address |
| beat_reg | output | RW | Beat register number |
| beat_repeat | output | 1 | Beat belongs to a split operation |
| beat_second | output | 1 | Beat is the second of a split operation |
| beat_irq_inhibit | output | 1 | Asynchronous and trace interrupts must not be taken on this beat |
| align_exc | output | 1 | Alignment exception pulse |
| illegal_exc | output | 1 | Illegal-form pulse |

## Verification
The bench targets an odd base register in little-endian mode. Here both beats name the same register, so a design that tests the register value instead of forcing bit 0 would mis-pair the beats. It sends 8-byte aligned quad stores and big-endian plain quad loads, which a too-strict alignment check would wrongly fault. It sends reserved loads that are both misaligned and colliding, where a design with the wrong precedence would raise the alignment pulse. It holds `dn_ready` low for random stretches, which exposes a design that advances or changes a beat without a handoff. It also pokes new requests during a split, where a design that accepts them would corrupt the second beat. Finally, it flushes between the two beats, where a design that only clears the first beat would leak a stray second beat.

// File: rtl/qs_pkg.sv
package qs_pkg;
  typedef enum logic [2:0] {
    QK_SINGLE  = 3'd0,
    QK_QLD     = 3'd1,
    QK_QST     = 3'd2,
    QK_QLD_RSV = 3'd3,
    QK_QST_CND = 3'd4
  } qs_kind_e;

  localparam int unsigned QS_BEATS = 2;
endpackage

// File: rtl/qs_classify.sv
module qs_classify
  import qs_pkg::*;
#(
  parameter int unsigned AW         = 64,
  parameter int unsigned RW         = 5,
  parameter int unsigned ALIGN_BITS = 4
) (
  input  logic [2:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic          big_endian,
  input  logic [RW-1:0] rt,
  input  logic [RW-1:0] ra,
  input  logic [RW-1:0] rb,
  output logic          is_quad,
  output logic          bad_form,
  output logic          bad_align
);
  logic misal;
  logic is_rsv;

  always_comb begin
    misal   = |addr[ALIGN_BITS-1:0];
    is_rsv  = (kind == QK_QLD_RSV);
    is_quad = (kind == QK_QLD) || (kind == QK_QST) ||
              (kind == QK_QLD_RSV) || (kind == QK_QST_CND);
    bad_form  = is_rsv && ((ra == rt) || (rb == rt));
    bad_align = misal && (is_rsv || ((kind == QK_QLD) && !big_endian));
  end
endmodule

// File: rtl/qs_beat_gen.sv
module qs_beat_gen
  import qs_pkg::*;
#(
  parameter int unsigned AW         = 64,
  parameter int unsigned RW         = 5,
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic                         is_quad,
  input  logic                         big_endian,
  input  logic [AW-1:0]                addr,
  input  logic [RW-1:0]                rt,
  output logic [QS_BEATS-1:0][AW-1:0]  beat_addr,
  output logic [QS_BEATS-1:0][RW-1:0]  beat_reg
);
  for (genvar b = 0; b < QS_BEATS; b++) begin : g_beat
    localparam logic [AW-1:0] OFS = AW'(b * BEAT_BYTES);
    localparam bit FIRST = (b == 0);
    logic odd_half;
    always_comb begin
      odd_half     = is_quad && (FIRST ? !big_endian : big_endian);
      beat_addr[b] = addr + OFS;
      beat_reg[b]  = odd_half ? (rt | RW'(1)) : rt;
    end
  end
endmodule

// File: rtl/quad_split_seq.sv
module quad_split_seq
  import qs_pkg::*;
#(
  parameter int unsigned AW         = 64,
  parameter int unsigned RW         = 5,
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic          req_big_endian,
  input  logic [RW-1:0] req_rt,
  input  logic [RW-1:0] req_ra,
  input  logic [RW-1:0] req_rb,
  input  logic          dn_ready,
  output logic          up_stall,
  output logic          beat_valid,
  output logic [AW-1:0] beat_addr,
  output logic [RW-1:0] beat_reg,
  output logic          beat_repeat,
  output logic          beat_second,
  output logic          beat_irq_inhibit,
  output logic          align_exc,
  output logic          illegal_exc
);
  localparam int unsigned ALIGN_BITS = $clog2(QS_BEATS * BEAT_BYTES);

  logic is_quad, bad_form, bad_align;
  logic [QS_BEATS-1:0][AW-1:0] g_addr;
  logic [QS_BEATS-1:0][RW-1:0] g_reg;

  qs_classify #(.AW(AW), .RW(RW), .ALIGN_BITS(ALIGN_BITS)) u_cls (
    .kind(req_kind), .addr(req_addr), .big_endian(req_big_endian),
    .rt(req_rt), .ra(req_ra), .rb(req_rb),
    .is_quad(is_quad), .bad_form(bad_form), .bad_align(bad_align)
  );

  qs_beat_gen #(.AW(AW), .RW(RW), .BEAT_BYTES(BEAT_BYTES)) u_gen (
    .is_quad(is_quad), .big_endian(req_big_endian), .addr(req_addr),
    .rt(req_rt), .beat_addr(g_addr), .beat_reg(g_reg)
  );

  logic          v_q, rep_q, sec_q, inh_q, pend_q, aexc_q, iexc_q;
  logic [AW-1:0] addr_q, nxt_addr_q;
  logic [RW-1:0] reg_q, nxt_reg_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      v_q        <= 1'b0;
      rep_q      <= 1'b0;
      sec_q      <= 1'b0;
      inh_q      <= 1'b0;
      pend_q     <= 1'b0;
      aexc_q     <= 1'b0;
      iexc_q     <= 1'b0;
      addr_q     <= '0;
      reg_q      <= '0;
      nxt_addr_q <= '0;
      nxt_reg_q  <= '0;
    end else begin
      aexc_q <= 1'b0;
      iexc_q <= 1'b0;
      if (!v_q) begin
        if (req_valid) begin
          if (bad_form) begin
            iexc_q <= 1'b1;
          end else if (bad_align) begin
            aexc_q <= 1'b1;
          end else begin
            v_q        <= 1'b1;
            addr_q     <= g_addr[0];
            reg_q      <= g_reg[0];
            rep_q      <= is_quad;
            sec_q      <= 1'b0;
            inh_q      <= 1'b0;
            pend_q     <= is_quad;
            nxt_addr_q <= g_addr[1];
            nxt_reg_q  <= g_reg[1];
          end
        end
      end else if (dn_ready) begin
        if (pend_q) begin
          addr_q <= nxt_addr_q;
          reg_q  <= nxt_reg_q;
          sec_q  <= 1'b1;
          inh_q  <= 1'b1;
          pend_q <= 1'b0;
        end else begin
          v_q   <= 1'b0;
          rep_q <= 1'b0;
          sec_q <= 1'b0;
          inh_q <= 1'b0;
        end
      end
    end
  end

  assign up_stall         = v_q;
  assign beat_valid       = v_q;
  assign beat_addr        = addr_q;
  assign beat_reg         = reg_q;
  assign beat_repeat      = rep_q;
  assign beat_second      = sec_q;
  assign beat_irq_inhibit = inh_q;
  assign align_exc        = aexc_q;
  assign illegal_exc      = iexc_q;
endmodule

// File: rtl/qs_checker.sv
module qs_checker #(
  parameter int unsigned AW = 64,
  parameter int unsigned RW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          dn_ready,
  input logic          beat_valid,
  input logic [AW-1:0] beat_addr,
  input logic [RW-1:0] beat_reg,
  input logic          beat_repeat,
  input logic          beat_second,
  input logic          beat_irq_inhibit,
  input logic          align_exc,
  input logic          illegal_exc
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !dn_ready && !flush) |=> (beat_valid && $stable(beat_addr) &&
      $stable(beat_reg) && $stable(beat_second) && $stable(beat_repeat)));

  assert_step_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && dn_ready && beat_repeat && !beat_second && !flush) |=>
      (beat_valid && beat_second && beat_addr == $past(beat_addr) + AW'(8)));

  assert_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && dn_ready && beat_repeat && !beat_second && !flush) |=>
      (beat_reg[RW-1:1] == $past(beat_reg[RW-1:1])));

  assert_second_flags_R3: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_second) |-> beat_repeat);

  assert_inhibit_R4: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_irq_inhibit == beat_second));

  assert_one_exc_R7: assert property (@(posedge clk) disable iff (rst)
    !(align_exc && illegal_exc));

  assert_exc_no_beat_R5: assert property (@(posedge clk) disable iff (rst)
    (align_exc || illegal_exc) |-> !beat_valid);

  assert_flush_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> !beat_valid);

  assert_single_R12: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_repeat) |-> (!beat_second && !beat_irq_inhibit));
endmodule

bind quad_split_seq qs_checker #(.AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .dn_ready(dn_ready),
  .beat_valid(beat_valid), .beat_addr(beat_addr), .beat_reg(beat_reg),
  .beat_repeat(beat_repeat), .beat_second(beat_second),
  .beat_irq_inhibit(beat_irq_inhibit), .align_exc(align_exc),
  .illegal_exc(illegal_exc)
);

// File: tb/sim_quad_split_seq.sv
module sim_quad_split_seq;
  localparam int AW = 64;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_big_endian = 1'b0;
  logic [RW-1:0] req_rt = '0, req_ra = '0, req_rb = '0;
  logic dn_ready = 1'b0;
  logic up_stall, beat_valid, beat_repeat, beat_second, beat_irq_inhibit;
  logic align_exc, illegal_exc;
  logic [AW-1:0] beat_addr;
  logic [RW-1:0] beat_reg;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  quad_split_seq #(.AW(AW), .RW(RW)) u0 (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_big_endian(req_big_endian),
    .req_rt(req_rt), .req_ra(req_ra), .req_rb(req_rb), .dn_ready(dn_ready),
    .up_stall(up_stall), .beat_valid(beat_valid), .beat_addr(beat_addr),
    .beat_reg(beat_reg), .beat_repeat(beat_repeat), .beat_second(beat_second),
    .beat_irq_inhibit(beat_irq_inhibit), .align_exc(align_exc),
    .illegal_exc(illegal_exc)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit f_quad(input logic [2:0] k);
    return (k >= 3'd1) && (k <= 3'd4);
  endfunction

  // 0 none, 1 alignment, 2 illegal
  function automatic int f_exc(input logic [2:0] k, input logic [AW-1:0] a,
                               input logic be, input logic [RW-1:0] rt,
                               input logic [RW-1:0] ra, input logic [RW-1:0] rb);
    if (k == 3'd3 && (ra == rt || rb == rt)) return 2;
    if (k == 3'd3 && a[3:0] != 4'd0) return 1;
    if (k == 3'd1 && !be && a[3:0] != 4'd0) return 1;
    return 0;
  endfunction

  function automatic logic [RW-1:0] f_reg(input bit quad, input logic be,
                                          input logic [RW-1:0] rt, input int idx);
    if (!quad) return rt;
    if (!be) return (idx == 0) ? (rt | 5'd1) : rt;
    return (idx == 1) ? (rt | 5'd1) : rt;
  endfunction

  task automatic run_op(input logic [2:0] k, input logic [AW-1:0] a, input logic be,
                        input logic [RW-1:0] rt, input logic [RW-1:0] ra,
                        input logic [RW-1:0] rb, input bit poke, input bit do_flush);
    int ex, nb, idx, guard;
    bit quad;
    quad = f_quad(k);
    ex = f_exc(k, a, be, rt, ra, rb);
    nb = quad ? 2 : 1;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_big_endian = be;
    req_rt = rt; req_ra = ra; req_rb = rb; dn_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (ex != 0) begin
      chk(align_exc == (ex == 1), "R5/R6 align pulse", align_exc, ex == 1);
      chk(illegal_exc == (ex == 2), "R7 illegal pulse", illegal_exc, ex == 2);
      chk(!beat_valid, "R5 no beat on exception", beat_valid, 0);
      @(negedge clk);
      chk(!align_exc && !illegal_exc && !up_stall && !beat_valid,
          "R7 pulse one cycle, idle after", {align_exc, illegal_exc, up_stall}, 0);
      return;
    end
    idx = 0; guard = 0;
    while (idx < nb && guard < 200) begin
      guard++;
      chk(beat_valid, "R1 beat present", beat_valid, 1);
      chk(up_stall, "R9 stall during op", up_stall, 1);
      chk(beat_addr == a + AW'(8 * idx), "R1 beat address", beat_addr, a + AW'(8 * idx));
      chk(beat_reg == f_reg(quad, be, rt, idx), "R2 beat register", beat_reg,
          f_reg(quad, be, rt, idx));
      chk(beat_repeat == quad && beat_second == (idx == 1),
          quad ? "R3 repeat/second" : "R12 single flags",
          {beat_repeat, beat_second}, {quad, idx == 1});
      chk(beat_irq_inhibit == (idx == 1), "R4 irq inhibit", beat_irq_inhibit, idx == 1);
      if (do_flush && idx == 1) begin
        flush = 1'b1; dn_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        chk(!beat_valid && !up_stall, "R10 flush cancels second beat",
            {beat_valid, up_stall}, 0);
        return;
      end
      dn_ready = ($urandom % 3) != 0;
      if (poke && guard == 1) begin
        req_valid = 1'b1; req_kind = 3'd0; req_addr = ~a; req_rt = ~rt;
      end else begin
        req_valid = 1'b0;
      end
      @(posedge clk);
      if (dn_ready) idx++;
      @(negedge clk);
      req_valid = 1'b0; dn_ready = 1'b0;
    end
    chk(!beat_valid && !up_stall, "R9 idle after last handoff", {beat_valid, up_stall}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!beat_valid && !up_stall && !align_exc && !illegal_exc, "R9 reset state",
        {beat_valid, up_stall, align_exc, illegal_exc}, 0);
    rst = 1'b0;
    // directed corners
    run_op(3'd1, 64'h1000, 1'b0, 5'd6, 5'd3, 5'd4, 0, 0); // R1 R2 LE
    run_op(3'd1, 64'h1000, 1'b1, 5'd6, 5'd3, 5'd4, 0, 0); // R2 BE
    run_op(3'd1, 64'h2000, 1'b0, 5'd7, 5'd3, 5'd4, 0, 0); // R2 odd base
    run_op(3'd1, 64'h1008, 1'b0, 5'd6, 5'd3, 5'd4, 0, 0); // R5
    run_op(3'd1, 64'h1008, 1'b1, 5'd6, 5'd3, 5'd4, 0, 0); // R8 BE load
    run_op(3'd2, 64'h1008, 1'b0, 5'd8, 5'd3, 5'd4, 0, 0); // R8 store
    run_op(3'd4, 64'h3018, 1'b0, 5'd8, 5'd3, 5'd4, 0, 0); // R8 cond store
    run_op(3'd3, 64'h1008, 1'b1, 5'd10, 5'd3, 5'd4, 0, 0); // R6 BE
    run_op(3'd3, 64'h1000, 1'b0, 5'd10, 5'd10, 5'd4, 0, 0); // R7 ra
    run_op(3'd3, 64'h1004, 1'b0, 5'd10, 5'd2, 5'd10, 0, 0); // R7 rb, precedence
    run_op(3'd3, 64'h1000, 1'b0, 5'd10, 5'd2, 5'd4, 0, 0); // rsv ok
    run_op(3'd0, 64'h1235, 1'b0, 5'd9, 5'd2, 5'd4, 0, 0); // R12
    run_op(3'd6, 64'h1230, 1'b1, 5'd9, 5'd2, 5'd4, 0, 0); // R12 unused kind
    run_op(3'd2, 64'h4000, 1'b0, 5'd12, 5'd2, 5'd4, 1, 0); // R9 poke
    run_op(3'd2, 64'h5000, 1'b1, 5'd12, 5'd2, 5'd4, 0, 1); // R10 flush
    run_op(3'd0, 64'h6000, 1'b0, 5'd1, 5'd2, 5'd4, 0, 0); // after flush
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [2:0] k;
      logic [AW-1:0] a;
      logic [RW-1:0] rt, ra, rb;
      k  = ($urandom % 8 < 6) ? 3'($urandom % 5) : 3'($urandom % 8);
      a  = {32'($urandom), 32'($urandom)};
      case ($urandom % 3)
        0: a[3:0] = 4'h0;
        1: a[3:0] = 4'h8;
        default: ;
      endcase
      rt = 5'($urandom);
      ra = ($urandom % 6 == 0) ? rt : 5'($urandom);
      rb = ($urandom % 6 == 0) ? rt : 5'($urandom);
      run_op(k, a, 1'($urandom), rt, ra, rb, ($urandom % 8) == 0, ($urandom % 10) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule